// File: doc/BRIEF.md
# Normal-Basis Field Inverter (Fermat Exponent Chain)

This block returns the multiplicative inverse of a field element of GF(2^n). The element is held in optimal normal basis form of type II. The inverse is the power a^(2^n − 2), which holds because a^(2^n − 1) = 1 for every non-zero a.

That power is reached by an addition chain driven by the bits of n−1, taken from the most significant bit down. Each step first squares the running partial power as many times as its current exponent length. It then multiplies the result by the copy of the partial power saved before the squarings. When the bit being consumed is one, the step adds one more squaring and a multiplication by the original operand. A last squaring finishes the power.

A squaring in a normal basis is a one-bit rotation, and the block spends one cycle on each. The multiplications go to an internal bit-serial normal-basis multiplier, which produces one product bit per cycle, so the multiplications set most of the latency. A start pulse accepts an operand. A zero operand is rejected at once: the block raises the error flag and returns zero without entering the chain.

Top module: `onb_fermat_inv`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done` and `err` are 0 and `result` is all zeros.
- R2: Encoding. Bit i of an element is the coefficient of beta^(2^i), where beta = gamma + gamma^-1 and gamma is a primitive (2N+1)-th root of unity. 2N+1 must be prime and 2 must be primitive modulo 2N+1. In this encoding the field's one is the all-ones vector. For every non-zero operand, the field product of `operand` and `result` is the all-ones vector.
- R3: For a non-zero operand, `result` equals operand^(2^N − 2) in the encoding of R2, which is the same as the product of the squarings operand^(2^i) for i = 1 … N−1.
- R4: A start with an all-zero operand raises `done` and `err` at the first clock edge after the start is sampled, with `result` all zeros.
- R5: `err` is cleared by a start accepted with a non-zero operand. It stays 0 through that whole computation.
- R6: Latency. Count the start edge as edge 1. For a non-zero operand, `done` rises at edge L. L is built as follows:
  - L starts at 2 and the length is 1.
  - For each bit of N−1 below its most significant bit, taken top down, add (length + N + 4) and then double the length.
  - If that bit is 1, also add N + 3 and increment the length.
  - This schedule issues floor(log2(N−1)) + HW(N−1) − 1 multiplications, each costing N + 2 cycles.
- R7: `done` is high for exactly one cycle per accepted start.
- R8: `result` changes only in the cycle in which `done` is high, and holds its value otherwise.
- R9: A start pulse that arrives while a computation is running is ignored. The running computation keeps its operand and its R6 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept `operand` and begin, when idle |
| operand | input | N | Element to invert, normal-basis bits |
| result | output | N | Inverse, valid when `done` is high, then held |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set when the accepted operand was zero |

## Verification
The bench sweeps every non-zero element of the default field and then adds seeded random operands. It checks each inverse against an independent multiplier built on the root-of-unity ring. A wrong rotation direction or a wrong multiplier bit order shows up there as a product other than the all-ones vector. Exact latency checks would catch a chain that skips the odd-bit multiplication or adds a squaring. A zero operand must finish after one edge with `err` set; a design that entered the chain would instead take the full latency and return garbage. A start pulse in the middle of a run checks that a busy controller does not reload its operand. A zero run followed by a non-zero run checks that the error flag really clears.

// File: rtl/onb_inv_pkg.sv
package onb_inv_pkg;

  typedef struct packed {
    logic loadIn;    // capture operand into working and original registers
    logic saveAcc;   // copy working register before a squaring run
    logic rotAcc;    // one squaring (rotation) of the working register
    logic mulGo;     // start the serial multiplier
    logic mulOrig;   // second factor is the original operand
    logic takeProd;  // working register takes the product
    logic finish;    // result takes the square of the working register
    logic zeroOut;   // result forced to zero
  } invStrobe_t;

  // Coefficient of beta in beta^(2^i) * beta^(2^j) for a type-II normal basis
  function automatic logic lambdaBit(input int n, input int i, input int j);
    int p;
    int pi;
    int pj;
    int s;
    int d;
    p  = 2 * n + 1;
    pi = 1;
    pj = 1;
    for (int k = 0; k < i; k++) pi = (pi * 2) % p;
    for (int k = 0; k < j; k++) pj = (pj * 2) % p;
    s = (pi + pj) % p;
    d = (pi - pj + p) % p;
    return (s == 1) || (s == p - 1) || (d == 1) || (d == p - 1);
  endfunction

endpackage

// File: rtl/onb_serial_mul.sv
module onb_serial_mul #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] prod,
  output logic         done
);
  import onb_inv_pkg::*;

  localparam int CW = $clog2(N + 1);

  logic [N-1:0]   aReg, bReg;
  logic [CW-1:0]  cnt;
  logic           busy;
  logic [N*N-1:0] terms;
  logic           bitOut;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam logic LAM = lambdaBit(N, i, j);
      assign terms[i*N+j] = LAM & aReg[i] & bReg[j];
    end
  end

  assign bitOut = ^terms;

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg <= '0;
      bReg <= '0;
      prod <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        aReg <= opA;
        bReg <= opB;
        cnt  <= CW'(N);
        busy <= 1'b1;
      end else if (busy) begin
        prod <= {bitOut, prod[N-1:1]};
        aReg <= {aReg[0], aReg[N-1:1]};
        bReg <= {bReg[0], bReg[N-1:1]};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/onb_inv_dpath.sv
module onb_inv_dpath #(
  parameter int N = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  onb_inv_pkg::invStrobe_t stb,
  input  logic [N-1:0]            operand,
  output logic                    operandZero,
  output logic                    mulDone,
  output logic [N-1:0]            result
);
  logic [N-1:0] acc, saved, orig, prod, opB, accSq;

  assign operandZero = (operand == '0);
  assign accSq       = {acc[N-2:0], acc[N-1]};
  assign opB         = stb.mulOrig ? orig : saved;

  onb_serial_mul #(.N(N)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .start(stb.mulGo),
    .opA  (acc),
    .opB  (opB),
    .prod (prod),
    .done (mulDone)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      saved  <= '0;
      orig   <= '0;
      result <= '0;
    end else begin
      if (stb.loadIn) begin
        acc  <= operand;
        orig <= operand;
      end else if (stb.rotAcc) begin
        acc <= accSq;
      end else if (stb.takeProd) begin
        acc <= prod;
      end
      if (stb.saveAcc) saved <= acc;
      if (stb.zeroOut) result <= '0;
      else if (stb.finish) result <= accSq;
    end
  end

endmodule

// File: rtl/onb_inv_ctrl.sv
module onb_inv_ctrl #(
  parameter int N = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    operandZero,
  input  logic                    mulDone,
  output onb_inv_pkg::invStrobe_t stb,
  output logic                    busy,
  output logic                    done,
  output logic                    err
);
  localparam int M      = N - 1;
  localparam int TOPBIT = $clog2(M + 1) - 1;
  localparam int LW     = $clog2(N + 1);
  localparam int BW     = $clog2(N) + 1;
  localparam logic [31:0] MVEC = 32'(M);

  typedef enum logic [3:0] {
    S_IDLE, S_SAVE, S_ROT, S_MULGO, S_MULWAIT,
    S_ODDROT, S_ODDGO, S_ODDWAIT, S_NEXT, S_FINAL
  } invState_t;

  invState_t     state;
  logic [LW-1:0] lenCnt, sqCnt;
  logic [BW-1:0] bitIdx;

  assign busy = (state != S_IDLE);

  always_comb begin
    stb = '0;
    unique case (state)
      S_IDLE: begin
        stb.loadIn  = start & ~operandZero;
        stb.zeroOut = start & operandZero;
      end
      S_SAVE:    stb.saveAcc  = 1'b1;
      S_ROT:     stb.rotAcc   = 1'b1;
      S_MULGO:   stb.mulGo    = 1'b1;
      S_MULWAIT: stb.takeProd = mulDone;
      S_ODDROT:  stb.rotAcc   = 1'b1;
      S_ODDGO: begin
        stb.mulGo   = 1'b1;
        stb.mulOrig = 1'b1;
      end
      S_ODDWAIT: stb.takeProd = mulDone;
      S_FINAL:   stb.finish   = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      lenCnt <= '0;
      sqCnt  <= '0;
      bitIdx <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (operandZero) begin
            err  <= 1'b1;
            done <= 1'b1;
          end else begin
            err    <= 1'b0;
            lenCnt <= LW'(1);
            bitIdx <= BW'(TOPBIT - 1);
            state  <= S_SAVE;
          end
        end
        S_SAVE: begin
          sqCnt <= lenCnt;
          state <= S_ROT;
        end
        S_ROT: begin
          sqCnt <= sqCnt - 1'b1;
          if (sqCnt == LW'(1)) state <= S_MULGO;
        end
        S_MULGO: state <= S_MULWAIT;
        S_MULWAIT: if (mulDone) begin
          lenCnt <= lenCnt << 1;
          state  <= MVEC[bitIdx] ? S_ODDROT : S_NEXT;
        end
        S_ODDROT: begin
          lenCnt <= lenCnt + 1'b1;
          state  <= S_ODDGO;
        end
        S_ODDGO: state <= S_ODDWAIT;
        S_ODDWAIT: if (mulDone) state <= S_NEXT;
        S_NEXT: begin
          if (bitIdx == '0) state <= S_FINAL;
          else begin
            bitIdx <= bitIdx - 1'b1;
            state  <= S_SAVE;
          end
        end
        S_FINAL: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/onb_fermat_inv.sv
module onb_fermat_inv #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] operand,
  output logic [N-1:0] result,
  output logic         done,
  output logic         err
);
  import onb_inv_pkg::*;

  invStrobe_t stb;
  logic       operandZero;
  logic       mulDone;
  logic       ctrlBusy;

  onb_inv_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .operandZero(operandZero),
    .mulDone    (mulDone),
    .stb        (stb),
    .busy       (ctrlBusy),
    .done       (done),
    .err        (err)
  );

  onb_inv_dpath #(.N(N)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .operand    (operand),
    .operandZero(operandZero),
    .mulDone    (mulDone),
    .result     (result)
  );

endmodule

// File: rtl/onb_inv_checker.sv
module onb_inv_checker #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [N-1:0] operand,
  input logic [N-1:0] result,
  input logic         done,
  input logic         err,
  input logic         busy
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (result == '0)); // R4

  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && operand == '0) |=> (done && err)); // R4

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && operand != '0) |=> (!err && !done)); // R5

  AST_ERR_QUIET_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !err); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R8

endmodule

bind onb_fermat_inv onb_inv_checker #(.N(N)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .operand(operand),
  .result (result),
  .done   (done),
  .err    (err),
  .busy   (ctrlBusy)
);

// File: tb/onb_fermat_inv_bench.sv
`timescale 1ns/1ps
module onb_fermat_inv_bench;
  localparam int N = 5;
  localparam int P = 2 * N + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] operand = '0;
  logic [N-1:0] result;
  logic         done, err;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  onb_fermat_inv #(.N(N)) u_onb_fermat_inv (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .result(result), .done(done), .err(err)
  );

  function automatic int pow2mod(input int e);
    int v = 1;
    for (int k = 0; k < e; k++) v = (v * 2) % P;
    return v;
  endfunction

  // Multiply through the ring of powers of gamma modulo gamma^P - 1
  function automatic logic [N-1:0] ringMul(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [P-1:0] rx = '0, ry = '0, rz = '0;
    logic [N-1:0] z;
    for (int i = 0; i < N; i++) begin
      int e = pow2mod(i);
      rx[e] ^= x[i]; rx[P-e] ^= x[i];
      ry[e] ^= y[i]; ry[P-e] ^= y[i];
    end
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        rz[(i + j) % P] ^= rx[i] & ry[j];
    if (rz[0]) rz = ~rz;
    for (int i = 0; i < N; i++) z[i] = rz[pow2mod(i)];
    return z;
  endfunction

  function automatic logic [N-1:0] expectInv(input logic [N-1:0] a);
    logic [N-1:0] acc = '1;
    logic [N-1:0] sq = a;
    for (int i = 1; i < N; i++) begin
      sq  = ringMul(sq, sq);
      acc = ringMul(acc, sq);
    end
    return acc;
  endfunction

  function automatic int expectLat();
    int m = N - 1;
    int top = 0;
    int len = 1;
    int lat = 2;
    while ((m >> (top + 1)) != 0) top++;
    for (int b = top - 1; b >= 0; b--) begin
      lat += len + N + 4;
      len *= 2;
      if ((m >> b) & 1) begin
        lat += N + 3;
        len += 1;
      end
    end
    return lat;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one operand; optional stray start with another operand after 'strayAt' cycles
  task automatic runOne(input logic [N-1:0] a, input int strayAt, input logic [N-1:0] strayVal);
    int cnt = 0;
    bit got = 0;
    @(negedge clk);
    operand = a;
    start = 1'b1;
    while (!got && cnt < 1000) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (strayAt > 0 && cnt == strayAt) begin
        operand = strayVal;
        start = 1'b1;
      end
      if (done) got = 1;
    end
    start = 1'b0;
    if (!got) begin
      check(1'b0, "watchdog", cnt, 0);
    end else if (a == '0) begin
      check(cnt == 1, "R4 latency", cnt, 1);
      check(err == 1'b1, "R4 err", err, 1);
      check(result == '0, "R4 result", result, 0);
    end else begin
      check(err == 1'b0, "R5 err", err, 0);
      check(ringMul(a, result) == '1, "R2 product", ringMul(a, result), '1);
      check(result == expectInv(a), "R3 power", result, expectInv(a));
      check(cnt == expectLat(), strayAt > 0 ? "R9 latency" : "R6 latency", cnt, expectLat());
    end
    @(negedge clk);
    check(done == 1'b0, "R7 pulse", done, 0);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog global", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    void'($urandom(32'h1dc3));
    repeat (3) @(negedge clk);
    check(done == 0 && err == 0, "R1 flags in reset", {done, err}, 0);
    check(result == '0, "R1 result in reset", result, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && err == 0 && result == '0, "R1 after reset", {done, err, result}, 0);

    for (int v = 1; v < (1 << N); v++) runOne(N'(v), 0, '0);

    runOne('0, 0, '0);
    runOne(N'(1), 0, '0);   // R5: err cleared after a zero run
    runOne('1, 0, '0);      // inverse of one is one

    runOne(N'(5), 4, N'(9));   // R9: stray start ignored
    runOne(N'(3), 12, '0);     // R9: stray zero start ignored

    for (int r = 0; r < 40; r++) begin
      logic [N-1:0] a = N'($urandom);
      if (($urandom % 8) == 0) a = '0;
      runOne(a, 0, '0);
    end

    held = result;
    repeat (6) @(negedge clk);
    check(result == held, "R8 result held", result, held);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule